// File: doc/BRIEF.md
# Parallel-Port Register Access Sequencer

This engine sits on the host side of a parallel-port link to a storage-device bridge and turns one register request into the fixed series of data-port and control-port updates that the bridge expects. It drives an 8-bit data port and a 4-bit control port, plus a direction line that turns the data lines into inputs. It samples the upper four status lines. A request names a register index, picks one of two register files (task registers or the control set), and gives a direction and, for writes, a data byte.

Every access opens with the same preamble: a select byte, the address byte and a zero byte, each framed by a fixed strobe train on the control port. Then comes a tail that depends on the direction and the read mode. In nibble mode a read byte is assembled from two successive status nibbles. In byte mode the data lines are turned around and read directly. A write sends its byte twice. Every port update is held for `HOLD` clock cycles. A one-cycle done pulse ends the access.

Top module: `pp_reg_seq`

## Requirements
- R1: The address byte driven on the data port after the first strobe train is (index << 2) + 1 + file, with file = 0 for task registers and 1 for the control set.
- R2: Strobe train A drives the control port with 5, 0xD, 5, 0xD, 5, 4 in that order, with the direction line low.
- R3: Strobe train B drives the control port with 5, 7, 5, 4 in that order, with the direction line low.
- R4: Every access begins with data 0x01 and train A, then the address byte and train B, then data 0x00 and train A.
- R5: A nibble-mode read (req_byte_mode = 0) then drives control 6, 4, 6, 4, 6, 4. The status nibble seen during the first 6 becomes rsp_data[3:0] and the nibble seen during the second 6 becomes rsp_data[7:4].
- R6: A byte-mode read (req_byte_mode = 1) then drives control 6 with pp_dir high, then 4, then 6 with pp_dir high, then 4. The data-port input seen during the first of these becomes rsp_data. pp_dir is high only together with control value 6.
- R7: A write then drives the write byte on the data port followed by train B, twice in succession, in either mode.
- R8: Each data or control update is held for exactly HOLD clock cycles before the next one.
- R9: A request is accepted only while req_ready is high. A request presented during an access has no effect: the current sequence runs unchanged, and the ports stay still afterwards.
- R10: rsp_done is high for exactly one cycle, HOLD × (number of steps) cycles after the accepting edge (25 steps for a nibble read, 23 for a byte read, 29 for a write). req_ready is high in that cycle, and read data is valid on rsp_data.
- R11: After reset, and whenever the engine is idle, the control port reads 4 with pp_dir low. Reset also clears the data port to 0, sets req_ready and clears rsp_done, and it does so even in the middle of an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle; request accepted when both high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_file | input | 1 | 0 = task registers, 1 = control set |
| req_index | input | IDX_W | Register index |
| req_wdata | input | 8 | Write data |
| req_byte_mode | input | 1 | 1 = byte-mode read, 0 = nibble-mode read |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_data | output | 8 | Read result |
| pp_data_o | output | 8 | Data port drive |
| pp_data_i | input | 8 | Data port read-back |
| pp_ctrl | output | 4 | Control port |
| pp_dir | output | 1 | Data port turned to input |
| pp_status | input | 4 | Upper status nibble |

## Verification
The bench builds the engine with HOLD = 2 and the default 3-bit index. With two cycles per step, the bench can tell the first cycle of every step from the later ones, so an off-by-one in the hold counter shows up. A full write of 29 steps still fits in about sixty cycles. With that hold length, a late request and a reset can both be placed exactly inside the preamble and inside the read tail. The bench's status and read-back model changes its answer on every fresh control-6 phase, so sampling in the wrong phase gives a visibly different byte.

// File: rtl/pp_reg_seq.sv
module pp_reg_seq #(
  parameter int HOLD  = 4,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic             req_file,
  input  logic [IDX_W-1:0] req_index,
  input  logic [7:0]       req_wdata,
  input  logic             req_byte_mode,
  output logic             rsp_done,
  output logic [7:0]       rsp_data,
  output logic [7:0]       pp_data_o,
  input  logic [7:0]       pp_data_i,
  output logic [3:0]       pp_ctrl,
  output logic             pp_dir,
  input  logic [3:0]       pp_status
);

  localparam int CW = (HOLD > 1) ? $clog2(HOLD) : 1;
  localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD - 1);
  localparam logic [4:0] LAST_WR  = 5'd28;
  localparam logic [4:0] LAST_NIB = 5'd24;
  localparam logic [4:0] LAST_BYT = 5'd22;

  localparam logic [2:0] K_DAT = 3'd0;
  localparam logic [2:0] K_CTL = 3'd1;
  localparam logic [2:0] K_SMA = 3'd2;
  localparam logic [2:0] K_SMB = 3'd3;
  localparam logic [2:0] K_SMD = 3'd4;

  function automatic logic [7:0] train_a(input logic [4:0] i);
    case (i)
      5'd0, 5'd2, 5'd4: train_a = 8'h05;
      5'd1, 5'd3:       train_a = 8'h0D;
      default:          train_a = 8'h04;
    endcase
  endfunction

  function automatic logic [7:0] train_b(input logic [4:0] i);
    case (i)
      5'd0, 5'd2: train_b = 8'h05;
      5'd1:       train_b = 8'h07;
      default:    train_b = 8'h04;
    endcase
  endfunction

  // {kind, value}; control values carry the direction flag in bit 5
  function automatic logic [10:0] step_fn(input logic [4:0] s, input logic wr,
                                          input logic bm, input logic [7:0] ad,
                                          input logic [7:0] wd);
    logic [4:0] t;
    t = s - 5'd19;
    if (s == 5'd0)       step_fn = {K_DAT, 8'h01};
    else if (s <= 5'd6)  step_fn = {K_CTL, train_a(s - 5'd1)};
    else if (s == 5'd7)  step_fn = {K_DAT, ad};
    else if (s <= 5'd11) step_fn = {K_CTL, train_b(s - 5'd8)};
    else if (s == 5'd12) step_fn = {K_DAT, 8'h00};
    else if (s <= 5'd18) step_fn = {K_CTL, train_a(s - 5'd13)};
    else if (wr) begin
      if (t == 5'd0 || t == 5'd5) step_fn = {K_DAT, wd};
      else if (t <= 5'd4)         step_fn = {K_CTL, train_b(t - 5'd1)};
      else                        step_fn = {K_CTL, train_b(t - 5'd6)};
    end else if (bm) begin
      case (t)
        5'd0:    step_fn = {K_SMD, 8'h26};
        5'd2:    step_fn = {K_CTL, 8'h26};
        default: step_fn = {K_CTL, 8'h04};
      endcase
    end else begin
      case (t)
        5'd0:    step_fn = {K_SMA, 8'h06};
        5'd2:    step_fn = {K_SMB, 8'h06};
        5'd4:    step_fn = {K_CTL, 8'h06};
        default: step_fn = {K_CTL, 8'h04};
      endcase
    end
  endfunction

  logic          busy;
  logic [4:0]    step;
  logic [CW-1:0] cnt;
  logic          lat_wr, lat_bm;
  logic [7:0]    lat_addr, lat_wd;

  logic          fire, end_step;
  logic [7:0]    in_addr;
  logic [4:0]    last_step;
  logic [10:0]   cur, nxt;

  assign req_ready = ~busy;
  assign fire      = req_valid & ~busy;
  assign end_step  = busy & (cnt == HOLD_LAST);
  assign in_addr   = 8'({req_index, 2'b00}) + 8'd1 + {7'd0, req_file};
  assign last_step = lat_wr ? LAST_WR : (lat_bm ? LAST_BYT : LAST_NIB);
  assign cur       = step_fn(step, lat_wr, lat_bm, lat_addr, lat_wd);
  assign nxt       = fire ? step_fn(5'd0, req_write, req_byte_mode, in_addr, req_wdata)
                          : step_fn(step + 5'd1, lat_wr, lat_bm, lat_addr, lat_wd);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      step      <= '0;
      cnt       <= '0;
      lat_wr    <= 1'b0;
      lat_bm    <= 1'b0;
      lat_addr  <= '0;
      lat_wd    <= '0;
      rsp_done  <= 1'b0;
      rsp_data  <= '0;
      pp_data_o <= '0;
      pp_ctrl   <= 4'h4;
      pp_dir    <= 1'b0;
    end else begin
      rsp_done <= 1'b0;
      if (fire || (end_step && step != last_step)) begin
        if (nxt[10:8] == K_DAT) pp_data_o <= nxt[7:0];
        else begin
          pp_ctrl <= nxt[3:0];
          pp_dir  <= nxt[5];
        end
      end
      if (fire) begin
        busy     <= 1'b1;
        step     <= '0;
        cnt      <= '0;
        lat_wr   <= req_write;
        lat_bm   <= req_byte_mode;
        lat_addr <= in_addr;
        lat_wd   <= req_wdata;
      end else if (busy) begin
        if (end_step) begin
          case (cur[10:8])
            K_SMA:   rsp_data[3:0] <= pp_status;
            K_SMB:   rsp_data[7:4] <= pp_status;
            K_SMD:   rsp_data      <= pp_data_i;
            default: ;
          endcase
          cnt <= '0;
          if (step == last_step) begin
            busy     <= 1'b0;
            rsp_done <= 1'b1;
          end else begin
            step <= step + 5'd1;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/pp_reg_seq_chk.sv
module pp_reg_seq_chk #(
  parameter int HOLD = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       rsp_done,
  input logic [7:0] pp_data_o,
  input logic [3:0] pp_ctrl,
  input logic       pp_dir
);

  logic [12:0] prev_out;
  logic [15:0] run;
  logic [12:0] cur_out;
  assign cur_out = {pp_data_o, pp_ctrl, pp_dir};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_out <= cur_out;
      run      <= 16'hFFFF;
    end else begin
      prev_out <= cur_out;
      if (cur_out != prev_out) run <= 16'd1;
      else if (run != 16'hFFFF) run <= run + 16'd1;
    end
  end

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> req_ready);

  a_r11_idle_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (pp_ctrl == 4'h4 && !pp_dir));

  a_r6_dir_with_six: assert property (@(posedge clk) disable iff (!rst_n)
    pp_dir |-> (pp_ctrl == 4'h6));

  a_r8_min_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && cur_out != prev_out) |-> (run >= 16'(HOLD)));

endmodule

bind pp_reg_seq pp_reg_seq_chk #(.HOLD(HOLD)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_done(rsp_done),
  .pp_data_o(pp_data_o), .pp_ctrl(pp_ctrl), .pp_dir(pp_dir)
);

// File: tb/sim_pp_reg_seq.sv
module sim_pp_reg_seq;
  localparam int HOLD = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, req_write = 1'b0, req_file = 1'b0, req_byte_mode = 1'b0;
  logic [2:0] req_index = '0;
  logic [7:0] req_wdata = '0;
  logic       req_ready, rsp_done, pp_dir;
  logic [7:0] rsp_data, pp_data_o, pp_data_i;
  logic [3:0] pp_ctrl, pp_status;

  pp_reg_seq #(.HOLD(HOLD), .IDX_W(3)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_file(req_file), .req_index(req_index),
    .req_wdata(req_wdata), .req_byte_mode(req_byte_mode), .rsp_done(rsp_done),
    .rsp_data(rsp_data), .pp_data_o(pp_data_o), .pp_data_i(pp_data_i),
    .pp_ctrl(pp_ctrl), .pp_dir(pp_dir), .pp_status(pp_status)
  );

  typedef struct packed {
    logic       wr;
    logic       bm;
    logic       file;
    logic [2:0] idx;
    logic [7:0] wd;
    logic [7:0] sa;
    logic [7:0] sb;
    logic [7:0] res;
  } vec_t;

  localparam vec_t VECS [0:7] = '{
    '{1'b0, 1'b0, 1'b0, 3'd7, 8'h00, 8'h5A, 8'hC3, 8'hC5},
    '{1'b0, 1'b0, 1'b1, 3'd6, 8'h00, 8'hF0, 8'h0F, 8'h0F},
    '{1'b0, 1'b1, 1'b0, 3'd0, 8'h00, 8'hA5, 8'h00, 8'hA5},
    '{1'b0, 1'b1, 1'b1, 3'd7, 8'h00, 8'h3C, 8'h00, 8'h3C},
    '{1'b1, 1'b0, 1'b0, 3'd6, 8'hA0, 8'h00, 8'h00, 8'h00},
    '{1'b1, 1'b1, 1'b1, 3'd7, 8'h5F, 8'h00, 8'h00, 8'h00},
    '{1'b0, 1'b0, 1'b0, 3'd1, 8'h00, 8'h9E, 8'h61, 8'h69},
    '{1'b0, 1'b1, 1'b0, 3'd3, 8'h00, 8'h00, 8'h00, 8'h00}
  };

  int total = 0, bad = 0;

  // bridge model: answers change with each fresh control-6 phase
  logic [7:0] cur_sa = '0, cur_sb = '0;
  logic [3:0] n6 = '0, nd = '0;
  logic       pc6 = 1'b0, pdir = 1'b0;
  always @(negedge clk) begin
    if (req_ready) begin
      n6 <= '0;
      nd <= '0;
    end else begin
      if (pp_ctrl == 4'h6 && !pp_dir && !pc6) n6 <= n6 + 4'd1;
      if (pp_dir && !pdir) nd <= nd + 4'd1;
    end
    pc6  <= (pp_ctrl == 4'h6 && !pp_dir);
    pdir <= pp_dir;
  end
  assign pp_status = (n6 == 4'd1) ? cur_sa[7:4] : (n6 == 4'd2) ? cur_sb[7:4] : ~cur_sa[7:4];
  assign pp_data_i = (nd == 4'd1) ? cur_sa : ~cur_sa;

  logic [7:0] ed [0:31];
  logic [3:0] ec [0:31];
  logic       edir [0:31];
  int         en;
  logic [7:0] cd;
  logic [3:0] cc;
  logic       cdr;

  task automatic put(input logic [7:0] d, input logic [3:0] c, input logic dr);
    ed[en] = d; ec[en] = c; edir[en] = dr; en++;
  endtask
  task automatic pdat(input logic [7:0] v); cd = v; put(cd, cc, cdr); endtask
  task automatic pctl(input logic [3:0] v, input logic dr); cc = v; cdr = dr; put(cd, cc, cdr); endtask
  task automatic tra; pctl(4'h5,0); pctl(4'hD,0); pctl(4'h5,0); pctl(4'hD,0); pctl(4'h5,0); pctl(4'h4,0); endtask
  task automatic trb; pctl(4'h5,0); pctl(4'h7,0); pctl(4'h5,0); pctl(4'h4,0); endtask

  task automatic build(input vec_t v);
    en = 0; cd = 8'h00; cc = 4'h4; cdr = 1'b0;
    pdat(8'h01); tra;
    pdat({v.idx, 2'b00} + 8'd1 + {7'd0, v.file}); trb;
    pdat(8'h00); tra;
    if (v.wr) begin
      pdat(v.wd); trb; pdat(v.wd); trb;
    end else if (v.bm) begin
      pctl(4'h6,1); pctl(4'h4,0); pctl(4'h6,1); pctl(4'h4,0);
    end else begin
      pctl(4'h6,0); pctl(4'h4,0); pctl(4'h6,0); pctl(4'h4,0); pctl(4'h6,0); pctl(4'h4,0);
    end
  endtask

  function automatic string tag_of(input int s, input vec_t v);
    if (s == 7) return "R1";
    if (s == 0 || s == 12) return "R4";
    if (s < 19) return (s >= 8 && s <= 11) ? "R3" : "R2";
    if (v.wr) return "R7";
    return v.bm ? "R6" : "R5";
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_reset;
    chk(pp_data_o == 8'h00 && pp_ctrl == 4'h4 && !pp_dir && req_ready && !rsp_done,
        "R11 reset state", {pp_data_o, pp_ctrl, 3'b0, pp_dir, 6'b0, req_ready, rsp_done},
        {8'h00, 4'h4, 4'h0, 8'h02});
  endtask

  task automatic run_vec(input vec_t v, input bit inject);
    build(v);
    cur_sa = v.sa; cur_sb = v.sb;
    req_write = v.wr; req_byte_mode = v.bm; req_file = v.file;
    req_index = v.idx; req_wdata = v.wd; req_valid = 1'b1;
    @(negedge clk);
    if (!inject) req_valid = 1'b0;
    for (int c = 0; c < en * HOLD; c++) begin
      if (inject && c == 10) begin
        req_write = ~v.wr; req_byte_mode = ~v.bm; req_index = 3'd0;
        req_file = ~v.file; req_wdata = 8'hFF;
      end
      chk({pp_data_o, pp_ctrl, pp_dir} == {ed[c/HOLD], ec[c/HOLD], edir[c/HOLD]},
          (c % HOLD == 0) ? tag_of(c/HOLD, v) : "R8",
          {19'd0, pp_data_o, pp_ctrl, pp_dir}, {19'd0, ed[c/HOLD], ec[c/HOLD], edir[c/HOLD]});
      if (c == 0 || c == 10) chk(!req_ready, "R9 busy", {31'd0, req_ready}, 32'd0);
      if (c == en * HOLD - 1) chk(!rsp_done, "R10 early done", {31'd0, rsp_done}, 32'd0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(rsp_done && req_ready, "R10 done", {30'd0, rsp_done, req_ready}, 32'd3);
    if (!v.wr) chk(rsp_data == v.res, v.bm ? "R6 data" : "R5 data", {24'd0, rsp_data}, {24'd0, v.res});
    @(negedge clk);
    chk(!rsp_done && req_ready, "R10 pulse", {30'd0, rsp_done, req_ready}, 32'd1);
    if (inject) begin
      for (int k = 0; k < 3; k++) begin
        chk(req_ready && pp_ctrl == 4'h4 && pp_data_o == ed[en-1], "R9 ignored",
            {19'd0, pp_data_o, pp_ctrl, req_ready}, {19'd0, ed[en-1], 4'h4, 1'b1});
        @(negedge clk);
      end
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_reset;
    for (int i = 0; i < 8; i++) begin
      run_vec(VECS[i], 1'b0);
      @(negedge clk);
    end
    // back-to-back: request held through the idle cycle after done
    run_vec(VECS[4], 1'b0);
    run_vec(VECS[0], 1'b0);
    // late request during an access is ignored
    run_vec(VECS[2], 1'b1);
    run_vec(VECS[5], 1'b1);
    // reset in the middle of a read tail
    req_write = 1'b0; req_byte_mode = 1'b1; req_index = 3'd2; req_file = 1'b0;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (40) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk_reset;
    rst_n = 1'b1;
    @(negedge clk);
    chk_reset;
    run_vec(VECS[6], 1'b0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule